// File: doc/BRIEF.md
# Page-Mode Read Sequencer

This block turns a stream of read requests into the activate, column-read and precharge command pulses of a DRAM-style memory. Every analog delay is expressed as a whole number of clock cycles. The block remembers which row is open. A request to that row goes straight to a column read. A request to any other row first closes the open row, waits out the precharge time, and then opens the new one.

Under the default timing, a request that finds no open row returns its data 5 cycles after the activate. Further reads to the same row return data every 2 cycles, which gives the 5-2-2-2 pattern. A row switch adds a precharge and a fresh activate. The precharge is also held back until the row has been open for the minimum active time.

The requester sees a single valid/ready handshake. Ready is high only while the sequencer can take a new request, so a held request waits through any command sequence and is then accepted without loss.

The controller is one state machine with these states:

| State | Role |
|---|---|
| ST_IDLE | No row open; waits for a request |
| ST_ACT | Issues the activate |
| ST_RCD | Waits out the activate-to-read delay |
| ST_READ | Issues the column read |
| ST_CCD | Waits out the read-to-read spacing |
| ST_OPEN | Row open; waits for a request |
| ST_RASW | Waits out the minimum active time |
| ST_PRE | Issues the precharge |
| ST_RP | Waits out the precharge time |

Its transitions are:
- *open*: ST_IDLE→ST_ACT on an accepted request.
- *settle*: ST_ACT→ST_RCD, or straight to ST_READ when T_RCD is 1.
- *strobe*: ST_RCD→ST_READ when the delay counter reaches zero.
- *space*: ST_READ→ST_CCD, or straight to ST_OPEN when T_CCD is 2.
- *park*: ST_CCD→ST_OPEN.
- *hit*: ST_OPEN→ST_READ when the row matches.
- *miss*: ST_OPEN→ST_PRE when the active time has been met, otherwise ST_OPEN→ST_RASW.
- *release*: ST_RASW→ST_PRE.
- *close*: ST_PRE→ST_RP, or straight to ST_ACT when T_RP is 1.
- *reopen*: ST_RP→ST_ACT.

Parameters are ROW_W, COL_W, T_RCD, T_CL, T_RP, T_RAS and T_CCD, all given in cycles. The defaults are 4, 4, 3, 2, 2, 6 and 2. T_CCD must be at least 2.

Top module: `pgrd_seq`

## Requirements
- R1: After reset, req_ready is 1, no command is issued, rd_valid is 0 and no row counts as open. The first request after reset therefore always takes the activate path.
- R2: A request accepted in cycle c while no row is open produces cmd_act in cycle c+1. cmd_row carries the requested row in that cycle.
- R3: cmd_rd follows its cmd_act by exactly T_RCD cycles. cmd_col carries the requested column in that cycle.
- R4: rd_valid pulses for one cycle exactly T_CL cycles after each cmd_rd. With the defaults, data follows the activate by 5 cycles.
- R5: A request accepted in cycle c whose row equals the open row produces cmd_rd in cycle c+1 with no activate. Back-to-back hits give reads T_CCD cycles apart (5-2-2-2 by default). The row stays open through any idle time.
- R6: A request accepted in cycle c to a row other than the open one produces cmd_pre, then cmd_act T_RP cycles later with the new row, then cmd_rd T_RCD cycles after that.
- R7: cmd_pre never comes earlier than T_RAS cycles after the last cmd_act. It is issued at max(c+1, act+T_RAS).
- R8: req_ready is high only in ST_IDLE and ST_OPEN. After a read it returns T_CCD-1 cycles later. A request held while ready is low is accepted in the first cycle ready is high.
- R9: At most one of cmd_act, cmd_rd and cmd_pre is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request present |
| req_row | input | ROW_W | Row address of the request |
| req_col | input | COL_W | Column address of the request |
| req_ready | output | 1 | Request accepted at this edge when valid |
| cmd_act | output | 1 | Activate (row open) command pulse |
| cmd_rd | output | 1 | Column read command pulse |
| cmd_pre | output | 1 | Precharge (row close) command pulse |
| cmd_row | output | ROW_W | Row address, valid with cmd_act |
| cmd_col | output | COL_W | Column address, valid with cmd_rd |
| rd_valid | output | 1 | Read data valid strobe |

## Verification
A stale open-row record shows up within one cycle of the next accepted request. It appears either as a read with no activate before it, or as an unneeded precharge. An off-by-one in a delay counter moves a command or the data strobe by a cycle on the very first access after reset. A broken active-time counter shows only on a miss that follows an activate closely, as a precharge arriving too early. For that reason the sweeps place misses directly behind first reads, with idle gaps between zero and several cycles.

// File: rtl/pgrd_pkg.sv
package pgrd_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ACT,
        ST_RCD,
        ST_READ,
        ST_CCD,
        ST_OPEN,
        ST_RASW,
        ST_PRE,
        ST_RP
    } pgrd_state_e;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        return m;
    endfunction

endpackage

// File: rtl/pgrd_row_track.sv
module pgrd_row_track #(
    parameter int ROW_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act,
    input  logic             pre,
    input  logic [ROW_W-1:0] act_row,
    input  logic [ROW_W-1:0] cmp_row,
    output logic             row_open,
    output logic             row_hit
);

    logic [ROW_W-1:0] open_row;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_open <= 1'b0;
            open_row <= '0;
        end else if (act) begin
            row_open <= 1'b1;
            open_row <= act_row;
        end else if (pre) begin
            row_open <= 1'b0;
        end
    end

    assign row_hit = row_open && (cmp_row == open_row);

endmodule

// File: rtl/pgrd_ras_timer.sv
module pgrd_ras_timer #(
    parameter int T_RAS = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act,
    output logic ras_near,
    output logic ras_done
);

    localparam int RAS_W = (T_RAS < 1) ? 1 : $clog2(T_RAS + 1);

    logic [RAS_W-1:0] since_act;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_act <= RAS_W'(T_RAS);
        end else if (act) begin
            since_act <= RAS_W'(1);
        end else if (since_act < RAS_W'(T_RAS)) begin
            since_act <= since_act + 1'b1;
        end
    end

    // ras_near: a precharge issued at the next edge meets the active time
    assign ras_near = (since_act >= RAS_W'(T_RAS - 1));
    assign ras_done = (since_act >= RAS_W'(T_RAS));

endmodule

// File: rtl/pgrd_lat_pipe.sv
module pgrd_lat_pipe #(
    parameter int T_CL = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_issue,
    output logic data_valid
);

    generate
        if (T_CL <= 1) begin : g_one
            logic stage;
            always_ff @(posedge clk) begin
                if (!rst_n) stage <= 1'b0;
                else        stage <= rd_issue;
            end
            assign data_valid = stage;
        end else begin : g_multi
            logic [T_CL-1:0] stages;
            always_ff @(posedge clk) begin
                if (!rst_n) stages <= '0;
                else        stages <= {stages[T_CL-2:0], rd_issue};
            end
            assign data_valid = stages[T_CL-1];
        end
    endgenerate

endmodule

// File: rtl/pgrd_seq.sv
module pgrd_seq
    import pgrd_pkg::*;
#(
    parameter int ROW_W = 4,
    parameter int COL_W = 4,
    parameter int T_RCD = 3,
    parameter int T_CL  = 2,
    parameter int T_RP  = 2,
    parameter int T_RAS = 6,
    parameter int T_CCD = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [ROW_W-1:0] req_row,
    input  logic [COL_W-1:0] req_col,
    output logic             req_ready,
    output logic             cmd_act,
    output logic             cmd_rd,
    output logic             cmd_pre,
    output logic [ROW_W-1:0] cmd_row,
    output logic [COL_W-1:0] cmd_col,
    output logic             rd_valid
);

    localparam int CNT_MAX = max3(T_RCD, T_RP, T_CCD);
    localparam int CNT_W   = (CNT_MAX < 2) ? 1 : $clog2(CNT_MAX);
    localparam int RCD_LD  = (T_RCD >= 2) ? T_RCD - 2 : 0;
    localparam int RP_LD   = (T_RP  >= 2) ? T_RP  - 2 : 0;
    localparam int CCD_LD  = (T_CCD >= 3) ? T_CCD - 3 : 0;

    pgrd_state_e       st, st_nx;
    logic [CNT_W-1:0]  wait_cnt;
    logic [ROW_W-1:0]  pend_row;
    logic [COL_W-1:0]  pend_col;
    logic              row_open, row_hit;
    logic              ras_near, ras_done;
    logic              accept;

    assign accept = req_valid && req_ready;

    pgrd_row_track #(.ROW_W(ROW_W)) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .act      (cmd_act),
        .pre      (cmd_pre),
        .act_row  (pend_row),
        .cmp_row  (req_row),
        .row_open (row_open),
        .row_hit  (row_hit)
    );

    pgrd_ras_timer #(.T_RAS(T_RAS)) u_ras (
        .clk      (clk),
        .rst_n    (rst_n),
        .act      (cmd_act),
        .ras_near (ras_near),
        .ras_done (ras_done)
    );

    pgrd_lat_pipe #(.T_CL(T_CL)) u_lat (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_issue   (cmd_rd),
        .data_valid (rd_valid)
    );

    // next-state selection
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: if (req_valid) st_nx = ST_ACT;
            ST_ACT:  st_nx = (T_RCD > 1) ? ST_RCD : ST_READ;
            ST_RCD:  if (wait_cnt == '0) st_nx = ST_READ;
            ST_READ: st_nx = (T_CCD > 2) ? ST_CCD : ST_OPEN;
            ST_CCD:  if (wait_cnt == '0) st_nx = ST_OPEN;
            ST_OPEN: begin
                if (req_valid) begin
                    if (row_hit)       st_nx = ST_READ;
                    else if (ras_near) st_nx = ST_PRE;
                    else               st_nx = ST_RASW;
                end
            end
            ST_RASW: if (ras_near) st_nx = ST_PRE;
            ST_PRE:  st_nx = (T_RP > 1) ? ST_RP : ST_ACT;
            ST_RP:   if (wait_cnt == '0) st_nx = ST_ACT;
            default: st_nx = ST_IDLE;
        endcase
    end

    // state register, delay counter and captured address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            wait_cnt <= '0;
            pend_row <= '0;
            pend_col <= '0;
        end else begin
            st <= st_nx;
            if (accept) begin
                pend_row <= req_row;
                pend_col <= req_col;
            end
            unique case (st)
                ST_ACT:  wait_cnt <= CNT_W'(RCD_LD);
                ST_PRE:  wait_cnt <= CNT_W'(RP_LD);
                ST_READ: wait_cnt <= CNT_W'(CCD_LD);
                ST_RCD, ST_RP, ST_CCD: begin
                    if (wait_cnt != '0) wait_cnt <= wait_cnt - 1'b1;
                end
                default: ;
            endcase
        end
    end

    // Moore outputs
    always_comb begin
        req_ready = (st == ST_IDLE) || (st == ST_OPEN);
        cmd_act   = (st == ST_ACT);
        cmd_rd    = (st == ST_READ);
        cmd_pre   = (st == ST_PRE);
        cmd_row   = cmd_act ? pend_row : '0;
        cmd_col   = cmd_rd  ? pend_col : '0;
    end

    // R2
    idle_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !row_open) |=> cmd_act);

    // R5
    hit_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && row_hit) |=> cmd_rd);

    // R3
    rd_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_rd |-> row_open);

    // R6
    act_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_act |-> !row_open);

    // R7
    pre_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_pre |-> ras_done);

    // R9
    one_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_act, cmd_rd, cmd_pre}));

    // R8
    ready_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !(cmd_act || cmd_rd || cmd_pre));

endmodule

// File: tb/sim_pgrd_seq.sv
`timescale 1ns/1ps
module sim_pgrd_seq;

    localparam int ROW_W = 4;
    localparam int COL_W = 4;
    localparam int T_RCD = 3;
    localparam int T_CL  = 2;
    localparam int T_RP  = 2;
    localparam int T_RAS = 6;
    localparam int T_CCD = 2;
    localparam int NEXP  = 1024;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [ROW_W-1:0] req_row = '0;
    logic [COL_W-1:0] req_col = '0;
    logic req_ready, cmd_act, cmd_rd, cmd_pre, rd_valid;
    logic [ROW_W-1:0] cmd_row;
    logic [COL_W-1:0] cmd_col;

    always #2.5 clk = ~clk;

    pgrd_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .T_RCD(T_RCD), .T_CL(T_CL),
               .T_RP(T_RP), .T_RAS(T_RAS), .T_CCD(T_CCD)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_row(req_row),
        .req_col(req_col), .req_ready(req_ready), .cmd_act(cmd_act),
        .cmd_rd(cmd_rd), .cmd_pre(cmd_pre), .cmd_row(cmd_row),
        .cmd_col(cmd_col), .rd_valid(rd_valid)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_fail = 0;

    // expected event lists, filled by the driver
    int               xa_cyc [NEXP]; logic [ROW_W-1:0] xa_row [NEXP]; int xa_n = 0, xa_i = 0;
    int               xp_cyc [NEXP]; int xp_n = 0, xp_i = 0;
    int               xr_cyc [NEXP]; logic [COL_W-1:0] xr_col [NEXP]; int xr_n = 0, xr_i = 0;
    int               xv_cyc [NEXP]; int xv_n = 0, xv_i = 0;

    // reference model state
    bit               m_open;
    logic [ROW_W-1:0] m_row;
    int               m_act;
    int               m_free;

    // monitor: compares every command and strobe with the expected lists
    always @(negedge clk) begin
        if (rst_n) begin
            if (cmd_act || cmd_rd || cmd_pre) begin
                n_chk++;
                if (int'(cmd_act) + int'(cmd_rd) + int'(cmd_pre) > 1) begin
                    n_fail++;
                    $display("FAIL R9 cycle %0d commands act/rd/pre=%b%b%b, expected at most one",
                             cyc, cmd_act, cmd_rd, cmd_pre);
                end
            end
            if (cmd_act) begin
                n_chk++;
                if (xa_i >= xa_n) begin
                    n_fail++;
                    $display("FAIL R2 unexpected activate at cycle %0d, expected none", cyc);
                end else begin
                    if (xa_cyc[xa_i] != cyc || xa_row[xa_i] != cmd_row) begin
                        n_fail++;
                        $display("FAIL R2/R6 activate cycle %0d row %0h, expected cycle %0d row %0h",
                                 cyc, cmd_row, xa_cyc[xa_i], xa_row[xa_i]);
                    end
                    xa_i++;
                end
            end
            if (cmd_pre) begin
                n_chk++;
                if (xp_i >= xp_n) begin
                    n_fail++;
                    $display("FAIL R6 unexpected precharge at cycle %0d, expected none", cyc);
                end else begin
                    if (xp_cyc[xp_i] != cyc) begin
                        n_fail++;
                        $display("FAIL R7 precharge cycle %0d, expected %0d", cyc, xp_cyc[xp_i]);
                    end
                    xp_i++;
                end
            end
            if (cmd_rd) begin
                n_chk++;
                if (xr_i >= xr_n) begin
                    n_fail++;
                    $display("FAIL R3 unexpected read at cycle %0d, expected none", cyc);
                end else begin
                    if (xr_cyc[xr_i] != cyc || xr_col[xr_i] != cmd_col) begin
                        n_fail++;
                        $display("FAIL R3/R5 read cycle %0d col %0h, expected cycle %0d col %0h",
                                 cyc, cmd_col, xr_cyc[xr_i], xr_col[xr_i]);
                    end
                    xr_i++;
                end
            end
            if (rd_valid) begin
                n_chk++;
                if (xv_i >= xv_n) begin
                    n_fail++;
                    $display("FAIL R4 unexpected data valid at cycle %0d, expected none", cyc);
                end else begin
                    if (xv_cyc[xv_i] != cyc) begin
                        n_fail++;
                        $display("FAIL R4 data valid cycle %0d, expected %0d", cyc, xv_cyc[xv_i]);
                    end
                    xv_i++;
                end
            end
        end
    end

    task automatic do_reset();
        req_valid = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state seen at the ports
        n_chk++;
        if (req_ready !== 1'b1 || cmd_act !== 1'b0 || cmd_rd !== 1'b0 ||
            cmd_pre !== 1'b0 || rd_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 after reset ready/act/rd/pre/valid=%b%b%b%b%b, expected 10000",
                     req_ready, cmd_act, cmd_rd, cmd_pre, rd_valid);
        end
        m_open = 1'b0;
        m_free = cyc;
        m_act  = -100;
    endtask

    task automatic push_act(input int c, input logic [ROW_W-1:0] r);
        xa_cyc[xa_n] = c; xa_row[xa_n] = r; xa_n++;
        m_act = c;
    endtask

    // called just after a falling edge; returns just after a falling edge
    task automatic send(input logic [ROW_W-1:0] r, input logic [COL_W-1:0] c, input int gap);
        int p, acc, want, pre_c, act_c, rd_c;
        req_valid = 1'b1;
        req_row   = r;
        req_col   = c;
        p = cyc;
        while (req_ready !== 1'b1) @(negedge clk);
        acc  = cyc;
        want = (p > m_free) ? p : m_free;
        n_chk++;
        if (acc != want) begin
            n_fail++;
            $display("FAIL R8 request accepted in cycle %0d, expected %0d", acc, want);
        end
        if (!m_open) begin
            act_c = acc + 1;
            push_act(act_c, r);
            rd_c = act_c + T_RCD;
        end else if (r == m_row) begin
            rd_c = acc + 1;
        end else begin
            pre_c = acc + 1;
            if (m_act + T_RAS > pre_c) pre_c = m_act + T_RAS;
            xp_cyc[xp_n] = pre_c; xp_n++;
            act_c = pre_c + T_RP;
            push_act(act_c, r);
            rd_c = act_c + T_RCD;
        end
        xr_cyc[xr_n] = rd_c; xr_col[xr_n] = c; xr_n++;
        xv_cyc[xv_n] = rd_c + T_CL; xv_n++;
        m_free = rd_c + T_CCD - 1;
        m_open = 1'b1;
        m_row  = r;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    bit done = 1'b0;

    task automatic finish_run();
        // every expected event must have been seen
        n_chk++;
        if (xa_i != xa_n || xp_i != xp_n || xr_i != xr_n || xv_i != xv_n) begin
            n_fail++;
            $display("FAIL R4 events seen act/pre/rd/valid=%0d/%0d/%0d/%0d, expected %0d/%0d/%0d/%0d",
                     xa_i, xp_i, xr_i, xv_i, xa_n, xp_n, xr_n, xv_n);
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        @(negedge clk);
        for (int gap = 0; gap <= 5; gap++) begin
            do_reset();
            // R1: first request after reset must open a row
            for (int m = 0; m < 16; m++) begin
                for (int i = 0; i < 4; i++) begin
                    send(m[i] ? ROW_W'(gap + 1) : ROW_W'(gap), COL_W'(m + i), gap);
                end
            end
            repeat (20) @(negedge clk);
        end
        // R5: hit after a long idle time; R6/R7: miss right behind a first read
        do_reset();
        send(ROW_W'(3), COL_W'(1), 40);
        send(ROW_W'(3), COL_W'(2), 0);
        send(ROW_W'(9), COL_W'(3), 0);
        send(ROW_W'(9), COL_W'(4), 0);
        send(ROW_W'(9), COL_W'(5), 0);
        repeat (20) @(negedge clk);
        // R1: reset closes the row, the same row is activated again
        do_reset();
        send(ROW_W'(9), COL_W'(6), 0);
        repeat (20) @(negedge clk);
        done = 1'b1;
        finish_run();
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R8 watchdog expired at cycle %0d, expected run to complete", cyc);
            finish_run();
        end
    end

endmodule